// File: doc/BRIEF.md
# Frame-Indexed Associative Address Translator

This block keeps one record per physical page frame, naming the virtual page that currently lives in that frame. To translate a virtual address made of a page number and an in-page offset, every record is compared with the requested page number in the same cycle. The position of the matching record is the frame number. The physical address is that frame number placed above the offset bits.

Software or a refill engine writes a single record at a time through the write port. A write either installs a page number and marks the record live, or marks the record dead. When no live record matches, the block reports a page fault and drives a zero address. Two live records that hold the same page are a table corruption. In that case the lowest-numbered frame wins and an error flag is raised. The lookup result is registered, so it appears one cycle after the request.

Top module: `frame_cam_xlate`

## Requirements
- R1: After reset, every record is dead and all result outputs are zero. A lookup of any page, including page 0, then returns a page fault.
- R2: A lookup presented in cycle t produces respValid in cycle t+1. On a hit, physAddr equals {frame, offset}, with the frame number in the upper FRAME_W bits and the offset in the lower OFF_W bits. frameIdx equals that frame.
- R3: When no live record holds the requested page, pageFault is 1, hit is 0, and physAddr and frameIdx are 0.
- R4: A write with wrValid=0 kills the addressed record, and later lookups of its page fault.
- R5: When several live records hold the requested page, the lowest frame number is returned with hit=1 and multiHit=1. A single match gives multiHit=0.
- R6: A write is seen by lookups from the next cycle on. A lookup in the same cycle as the write sees the old contents.
- R7: In a cycle with no lookup request the cycle before, respValid, hit, pageFault and multiHit are 0 and physAddr is 0.
- R8: Rewriting a live record with a new page replaces the old mapping. The old page stops resolving to that frame.
- R9: With respValid high, exactly one of hit and pageFault is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Translation request this cycle |
| lookupPage | input | PAGE_W (8) | Virtual page number to find |
| lookupOffset | input | OFF_W (10) | Offset inside the page |
| wrEn | input | 1 | Write one record this cycle |
| wrFrame | input | FRAME_W (4) | Frame whose record is written |
| wrPage | input | PAGE_W (8) | Page number installed on a load |
| wrValid | input | 1 | 1 loads the record live, 0 kills it |
| respValid | output | 1 | Result of last cycle's request |
| hit | output | 1 | A live record matched |
| pageFault | output | 1 | No live record matched |
| multiHit | output | 1 | More than one live record matched |
| frameIdx | output | FRAME_W (4) | Matching frame number, 0 on fault |
| physAddr | output | FRAME_W+OFF_W (14) | {frame, offset}, 0 on fault |

## Verification
The hardest case to reach is the duplicate-page condition. A correct refill engine never creates it, so the bench deliberately loads the same page into two frames. It then checks the lowest-frame choice and the error flag. Next it kills the lower record to show that the higher frame takes over cleanly. The write-versus-lookup collision is reached by driving a load and a lookup of the same page on the same clock edge. The bench expects a fault there and a hit one cycle later.

// File: rtl/frame_cam_pkg.sv
package frame_cam_pkg;
  typedef struct packed {
    logic load;    // install page and mark record live
    logic clear;   // mark record dead
    logic sample;  // capture a lookup result this edge
  } camStrobe_t;
endpackage

// File: rtl/frame_cam_ctrl.sv
module frame_cam_ctrl
  import frame_cam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lookupValid,
  input  logic       wrEn,
  input  logic       wrValid,
  output camStrobe_t strobe,
  output logic       respValid
);
  always_comb begin
    strobe.load   = wrEn && wrValid;
    strobe.clear  = wrEn && !wrValid;
    strobe.sample = lookupValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= lookupValid;
  end
endmodule

// File: rtl/frame_cam_dp.sv
module frame_cam_dp
  import frame_cam_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 10,
  parameter int NUM_FRAMES = 16,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  camStrobe_t               strobe,
  input  logic [PAGE_W-1:0]        lookupPage,
  input  logic [OFF_W-1:0]         lookupOffset,
  input  logic [FRAME_W-1:0]       wrFrame,
  input  logic [PAGE_W-1:0]        wrPage,
  output logic                     hit,
  output logic                     pageFault,
  output logic                     multiHit,
  output logic [FRAME_W-1:0]       frameIdx,
  output logic [FRAME_W+OFF_W-1:0] physAddr
);
  localparam int PA_W = FRAME_W + OFF_W;

  logic [PAGE_W-1:0]     entryPage [NUM_FRAMES];
  logic [NUM_FRAMES-1:0] entryValid;
  logic [NUM_FRAMES-1:0] matchVec;
  logic [FRAME_W-1:0]    firstIdx;
  logic                  anyMatch;
  logic                  manyMatch;

  // record storage: one write per cycle, visible from the next cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entryValid <= '0;
      for (int f = 0; f < NUM_FRAMES; f++) entryPage[f] <= '0;
    end else begin
      for (int f = 0; f < NUM_FRAMES; f++) begin
        if (wrFrame == FRAME_W'(f)) begin
          if (strobe.load) begin
            entryValid[f] <= 1'b1;
            entryPage[f]  <= wrPage;
          end else if (strobe.clear) begin
            entryValid[f] <= 1'b0;
          end
        end
      end
    end
  end

  // parallel compare, one comparator per frame
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_cmp
    assign matchVec[g] = entryValid[g] && (entryPage[g] == lookupPage);
  end

  // lowest-index priority encoder
  always_comb begin
    firstIdx = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (matchVec[i]) firstIdx = FRAME_W'(i);
    end
  end

  assign anyMatch  = |matchVec;
  assign manyMatch = |(matchVec & (matchVec - NUM_FRAMES'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.sample) begin
      hit       <= 1'b0;
      pageFault <= 1'b0;
      multiHit  <= 1'b0;
      frameIdx  <= '0;
      physAddr  <= '0;
    end else begin
      hit       <= anyMatch;
      pageFault <= !anyMatch;
      multiHit  <= manyMatch;
      frameIdx  <= anyMatch ? firstIdx : '0;
      physAddr  <= anyMatch ? {firstIdx, lookupOffset} : PA_W'(0);
    end
  end
endmodule

// File: rtl/frame_cam_xlate.sv
module frame_cam_xlate
  import frame_cam_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFF_W      = 10,
  parameter int NUM_FRAMES = 16,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookupValid,
  input  logic [PAGE_W-1:0]        lookupPage,
  input  logic [OFF_W-1:0]         lookupOffset,
  input  logic                     wrEn,
  input  logic [FRAME_W-1:0]       wrFrame,
  input  logic [PAGE_W-1:0]        wrPage,
  input  logic                     wrValid,
  output logic                     respValid,
  output logic                     hit,
  output logic                     pageFault,
  output logic                     multiHit,
  output logic [FRAME_W-1:0]       frameIdx,
  output logic [FRAME_W+OFF_W-1:0] physAddr
);
  camStrobe_t strobe;

  frame_cam_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lookupValid(lookupValid),
    .wrEn       (wrEn),
    .wrValid    (wrValid),
    .strobe     (strobe),
    .respValid  (respValid)
  );

  frame_cam_dp #(
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .NUM_FRAMES(NUM_FRAMES),
    .FRAME_W   (FRAME_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .lookupPage  (lookupPage),
    .lookupOffset(lookupOffset),
    .wrFrame     (wrFrame),
    .wrPage      (wrPage),
    .hit         (hit),
    .pageFault   (pageFault),
    .multiHit    (multiHit),
    .frameIdx    (frameIdx),
    .physAddr    (physAddr)
  );
endmodule

// File: rtl/frame_cam_chk.sv
module frame_cam_chk #(
  parameter int OFF_W   = 10,
  parameter int FRAME_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     lookupValid,
  input logic [OFF_W-1:0]         lookupOffset,
  input logic                     respValid,
  input logic                     hit,
  input logic                     pageFault,
  input logic                     multiHit,
  input logic [FRAME_W-1:0]       frameIdx,
  input logic [FRAME_W+OFF_W-1:0] physAddr
);
  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> (hit ^ pageFault));

  // R5
  multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multiHit |-> hit);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !respValid |-> (!hit && !pageFault && !multiHit && physAddr == '0));

  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> respValid);

  // R2
  addr_compose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid ##1 hit) |->
      (physAddr[OFF_W-1:0] == $past(lookupOffset) &&
       physAddr[FRAME_W+OFF_W-1:OFF_W] == frameIdx));

  // R3
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pageFault |-> (physAddr == '0 && frameIdx == '0 && !multiHit));
endmodule

bind frame_cam_xlate frame_cam_chk #(
  .OFF_W  (OFF_W),
  .FRAME_W(FRAME_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lookupValid (lookupValid),
  .lookupOffset(lookupOffset),
  .respValid   (respValid),
  .hit         (hit),
  .pageFault   (pageFault),
  .multiHit    (multiHit),
  .frameIdx    (frameIdx),
  .physAddr    (physAddr)
);

// File: tb/tb_frame_cam_xlate.sv
`timescale 1ns/1ps
module tb_frame_cam_xlate;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 10;
  localparam int NF     = 16;
  localparam int FW     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookupValid = 1'b0;
  logic [PAGE_W-1:0] lookupPage = '0;
  logic [OFF_W-1:0] lookupOffset = '0;
  logic wrEn = 1'b0;
  logic [FW-1:0] wrFrame = '0;
  logic [PAGE_W-1:0] wrPage = '0;
  logic wrValid = 1'b0;
  logic respValid, hit, pageFault, multiHit;
  logic [FW-1:0] frameIdx;
  logic [FW+OFF_W-1:0] physAddr;

  always #2.5 clk = ~clk;

  frame_cam_xlate dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupPage(lookupPage),
    .lookupOffset(lookupOffset), .wrEn(wrEn), .wrFrame(wrFrame), .wrPage(wrPage),
    .wrValid(wrValid), .respValid(respValid), .hit(hit), .pageFault(pageFault),
    .multiHit(multiHit), .frameIdx(frameIdx), .physAddr(physAddr)
  );

  typedef struct {
    logic rv, h, pf, mh;
    logic [FW-1:0] fi;
    logic [FW+OFF_W-1:0] pa;
    string tag;
  } exp_t;

  exp_t sbq[$];
  logic mValid [NF];
  logic [PAGE_W-1:0] mPage [NF];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  function automatic exp_t predict(logic lv, logic [PAGE_W-1:0] pg, logic [OFF_W-1:0] off);
    exp_t e;
    int n;
    e.rv = lv; e.h = 0; e.pf = 0; e.mh = 0; e.fi = '0; e.pa = '0; e.tag = "";
    n = 0;
    if (lv) begin
      for (int f = NF - 1; f >= 0; f--) begin
        if (mValid[f] && mPage[f] == pg) begin
          n++;
          e.fi = FW'(f);
        end
      end
      e.h  = (n > 0);
      e.pf = (n == 0);
      e.mh = (n > 1);
      e.pa = (n > 0) ? {e.fi, off} : '0;
    end
    return e;
  endfunction

  task automatic step(input logic lv, input logic [PAGE_W-1:0] pg,
                      input logic [OFF_W-1:0] off, input logic we,
                      input logic [FW-1:0] wf, input logic [PAGE_W-1:0] wp,
                      input logic wv, input string tag);
    exp_t e;
    @(negedge clk);
    lookupValid = lv; lookupPage = pg; lookupOffset = off;
    wrEn = we; wrFrame = wf; wrPage = wp; wrValid = wv;
    e = predict(lv, pg, off);   // same-cycle lookup sees old contents
    e.tag = tag;
    sbq.push_back(e);
    if (we) begin
      mValid[wf] = wv;
      if (wv) mPage[wf] = wp;
    end
  endtask

  task automatic look(input logic [PAGE_W-1:0] pg, input logic [OFF_W-1:0] off, input string tag);
    step(1'b1, pg, off, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic load(input logic [FW-1:0] wf, input logic [PAGE_W-1:0] wp);
    step(1'b0, '0, '0, 1'b1, wf, wp, 1'b1, "WR");
  endtask

  task automatic kill(input logic [FW-1:0] wf);
    step(1'b0, '0, '0, 1'b1, wf, '0, 1'b0, "WR");
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  // monitor: one expected item per driven cycle
  initial forever begin
    exp_t e;
    @(posedge clk);
    #1;
    if (rst_n && sbq.size() > 0) begin
      e = sbq.pop_front();
      compared++;
      if (respValid !== e.rv || hit !== e.h || pageFault !== e.pf ||
          multiHit !== e.mh || frameIdx !== e.fi || physAddr !== e.pa) begin
        mismatched++;
        $display("FAIL %s: actual rv=%b h=%b pf=%b mh=%b fi=%0d pa=%h expected rv=%b h=%b pf=%b mh=%b fi=%0d pa=%h",
                 e.tag, respValid, hit, pageFault, multiHit, frameIdx, physAddr,
                 e.rv, e.h, e.pf, e.mh, e.fi, e.pa);
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin mValid[f] = 0; mPage[f] = '0; end
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (respValid !== 0 || hit !== 0 || pageFault !== 0 || multiHit !== 0 || physAddr !== '0) begin
      mismatched++;
      $display("FAIL R1 reset outputs: actual rv=%b h=%b pf=%b mh=%b pa=%h expected all zero",
               respValid, hit, pageFault, multiHit, physAddr);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all records dead after reset, page 0 included
    look(8'h00, 10'h000, "R1");
    look(8'h12, 10'h3ff, "R1");
    // R7: no request -> quiet outputs
    idle("R7");
    // R2: hits at several frames
    load(4'd3, 8'h12);
    load(4'd0, 8'hA5);
    load(4'd15, 8'hFF);
    look(8'h12, 10'h155, "R2");
    look(8'hA5, 10'h001, "R2");
    look(8'hFF, 10'h3ff, "R2");
    idle("R7");
    // R3: unmapped page faults
    look(8'h13, 10'h2aa, "R3");
    // R6: load and lookup on the same edge, then the next cycle
    step(1'b1, 8'h40, 10'h123, 1'b1, 4'd5, 8'h40, 1'b1, "R6");
    look(8'h40, 10'h123, "R6");
    // R4: kill frame 3
    kill(4'd3);
    look(8'h12, 10'h155, "R4");
    // R5: duplicate page in frames 9 and 7
    load(4'd9, 8'h77);
    load(4'd7, 8'h77);
    look(8'h77, 10'h0f0, "R5");
    kill(4'd7);
    look(8'h77, 10'h0f0, "R5");
    // R8: overwrite frame 9
    load(4'd9, 8'h78);
    look(8'h77, 10'h011, "R8");
    look(8'h78, 10'h011, "R8");
    // R6: kill and lookup on the same edge
    step(1'b1, 8'hFF, 10'h0aa, 1'b1, 4'd15, 8'h00, 1'b0, "R6");
    look(8'hFF, 10'h0aa, "R6");
    // R9: mixed back-to-back pattern
    for (int i = 0; i < 40; i++) begin
      logic [PAGE_W-1:0] pg;
      pg = (i % 3 == 0) ? 8'h40 : PAGE_W'(i * 37);
      if (i % 7 == 0) load(FW'(i), PAGE_W'(i * 37));
      look(pg, OFF_W'(i * 91), "R9");
    end
    idle("R7");
    idle("R7");
    while (sbq.size() > 0) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule